// File: doc/BRIEF.md
# PLL Integral-Gain Calibration Sequencer

This block sets the integral-path gain of a dual-path charge-pump PLL. It works in the reference clock domain. The gain knob is the number of enabled integral charge-pump current slices. For every calibration point the sequencer turns the proportional path off and waits for the loop to settle. It then asks the feedback divider for a small phase advance and counts reference cycles until a bang-bang phase detector settles on the opposite polarity. It repeats this with a phase retard. The two times are averaged, which cancels a static input-referred phase offset.

The average is compared with a target crossover time. If the loop crosses over too slowly, one slice is added. If it crosses over too quickly, one slice is removed. The sequencer then settles again and measures again. Stepping ends when the error reaches zero, when the error changes sign, or when the code reaches a limit. If a crossover never arrives, a counter limit aborts the run and flags an error. When the run ends, the proportional path is enabled again.

Top module: `pll_igain_cal`

## Requirements
- R1: After reset, `slice_en` is the thermometer code for 5 of 10 slices, with bit i high when more than i slices are on, so it reads 10'h01F. `prop_off`, `step_req`, `done` and `err` are all low.
- R2: `prop_off` is high from the cycle after an accepted `start` until the cycle in which `done` pulses. It is high during every `step_req`, and it is low when `done` is high.
- R3: Each calibration point issues two one-cycle `step_req` pulses. The first has `step_retard`=0 (advance) and the second has `step_retard`=1. During each pulse, `step_amt` equals the `step_size` value captured at `start`.
- R4: The crossover time of a step is the number of reference cycles from the first cycle after `step_req` until the first of two consecutive samples in which `bb_lead` equals `step_retard`. A single-cycle flip of `bb_lead` that is not confirmed on the next sample does not end the measurement.
- R5: Before each step there is a settle interval of max(`settle_cyc`,1) cycles. The retard `step_req` therefore comes exactly D+3+max(`settle_cyc`,1) cycles after the advance `step_req`, where D is the advance crossover time.
- R6: The average of a point is floor((advance time + retard time)/2). If the average is above `target_cyc`, one slice is added. If it is below, one slice is removed. The code changes by exactly one slice per point.
- R7: Stepping stops without a change when the average equals the target, when the error sign differs from that of the previous step in the same run, or when a slice must be added at 10 or removed at 1.
- R8: If no crossover is confirmed within `timeout_cyc` measurement cycles, the run ends. `err` goes high, `done` pulses, and the slice code keeps the value it had when that point started.
- R9: A `start` pulse that arrives while a run is in progress is ignored. That run still ends with one `done` pulse and with the same result.
- R10: `done` is a one-cycle pulse. `err` stays set after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run (accepted only when idle) |
| bb_lead | input | 1 | Bang-bang phase detector output bit |
| target_cyc | input | CW | Target averaged crossover time, in reference cycles |
| step_size | input | SW | Phase step magnitude, in prescaler-output periods |
| settle_cyc | input | CW | Relock interval before each step |
| timeout_cyc | input | CW | Measurement cycle limit without a crossover |
| step_req | output | 1 | One-cycle request for a divider phase step |
| step_retard | output | 1 | Step polarity: 0 = advance, 1 = retard |
| step_amt | output | SW | Step magnitude to apply |
| prop_off | output | 1 | Disables the proportional path |
| slice_en | output | NSLICE | Thermometer enables of the integral slices |
| done | output | 1 | Run finished (one-cycle pulse) |
| err | output | 1 | Last run aborted on a missing crossover |

## Verification
The bench acts as the loop. At each step it drives `bb_lead` with the old polarity for a delay that falls as the slice count rises, then holds the new polarity. An offset is added to the advance delay and subtracted from the retard delay, so the final code shows whether the two measurements are combined to cancel the offset. Targets that match the starting point exactly, or lie below or above the whole reachable range, separate the equality stop from the two limit stops. Random targets and slopes exercise the stop on a sign change. Single-sample dither before the crossover, measured through the spacing between step requests, tells a filtered crossover apart from a raw one. A detector that never flips shows whether the timeout path leaves the code unchanged.

// File: rtl/pll_cal_pkg.sv
package pll_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_STEP,
    ST_MEAS,
    ST_EVAL
  } cal_state_t;
endpackage

// File: rtl/pll_xover_meas.sv
// Counts reference cycles after a phase step and confirms the polarity flip
// of the bang-bang detector over two consecutive samples.
module pll_xover_meas #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          en,
  input  logic          dir,
  input  logic          bb,
  input  logic [CW-1:0] timeout,
  output logic          hit,
  output logic          tout,
  output logic [CW-1:0] t_out
);
  logic [CW-1:0] cnt;
  logic          hold;
  logic          match;
  logic [CW:0]   cnt_nxt;

  assign match   = (bb == dir);
  assign cnt_nxt = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
  assign hit     = en & match & hold;
  assign tout    = en & ~hit & (cnt_nxt >= {1'b0, timeout});
  assign t_out   = cnt - {{(CW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      hold <= 1'b0;
    end else if (arm) begin
      cnt  <= '0;
      hold <= 1'b0;
    end else if (en) begin
      if (!cnt_nxt[CW]) cnt <= cnt_nxt[CW-1:0];
      hold <= match;
    end
  end

  // R4
  xover_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($past(en) && ($past(bb) == dir)));
endmodule

// File: rtl/pll_gain_ctrl.sv
// Holds the integral slice code and applies the one-slice step rule.
module pll_gain_ctrl #(
  parameter int NSLICE    = 10,
  parameter int INIT_CODE = 5,
  parameter int CW        = 16,
  localparam int KW       = $clog2(NSLICE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              eval,
  input  logic [CW-1:0]     t_adv,
  input  logic [CW-1:0]     t_ret,
  input  logic [CW-1:0]     target,
  output logic              stop,
  output logic [NSLICE-1:0] slice_en
);
  logic [KW-1:0] code;
  logic          have_dir;
  logic          last_up;
  logic [CW:0]   sum;
  logic [CW-1:0] avg;
  logic          up, down, at_top, at_bot, apply;

  assign sum    = {1'b0, t_adv} + {1'b0, t_ret};
  assign avg    = sum[CW:1];
  assign up     = (avg > target);
  assign down   = (avg < target);
  assign at_top = (code == KW'(NSLICE));
  assign at_bot = (code == KW'(1));

  always_comb begin
    stop = 1'b0;
    if (eval) begin
      if (!up && !down)                stop = 1'b1;
      else if (have_dir && (up != last_up)) stop = 1'b1;
      else if (up && at_top)           stop = 1'b1;
      else if (down && at_bot)         stop = 1'b1;
    end
  end
  assign apply = eval & ~stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code     <= KW'(INIT_CODE);
      have_dir <= 1'b0;
      last_up  <= 1'b0;
    end else if (clr) begin
      have_dir <= 1'b0;
    end else if (apply) begin
      code     <= up ? code + KW'(1) : code - KW'(1);
      have_dir <= 1'b1;
      last_up  <= up;
    end
  end

  for (genvar i = 0; i < NSLICE; i++) begin : g_therm
    assign slice_en[i] = (code > KW'(i));
  end

  // R7
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code >= KW'(1)) && (code <= KW'(NSLICE)));
  // R6
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code != $past(code)) |-> ((code == $past(code) + KW'(1)) || (code + KW'(1) == $past(code))));
  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> $stable(code));
endmodule

// File: rtl/pll_igain_cal.sv
module pll_igain_cal
  import pll_cal_pkg::*;
#(
  parameter int CW        = 16,
  parameter int SW        = 8,
  parameter int NSLICE    = 10,
  parameter int INIT_CODE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bb_lead,
  input  logic [CW-1:0]     target_cyc,
  input  logic [SW-1:0]     step_size,
  input  logic [CW-1:0]     settle_cyc,
  input  logic [CW-1:0]     timeout_cyc,
  output logic              step_req,
  output logic              step_retard,
  output logic [SW-1:0]     step_amt,
  output logic              prop_off,
  output logic [NSLICE-1:0] slice_en,
  output logic              done,
  output logic              err
);
  cal_state_t    state;
  logic          phase;
  logic [CW-1:0] scnt;
  logic [CW:0]   scnt_nxt;
  logic [CW-1:0] t_adv, t_ret, t_meas;
  logic [SW-1:0] amt_q;
  logic          done_q, err_q;
  logic          hit, tout, stop, accept;

  assign accept      = (state == ST_IDLE) & start;
  assign scnt_nxt    = {1'b0, scnt} + {{CW{1'b0}}, 1'b1};
  assign step_req    = (state == ST_STEP);
  assign step_retard = phase;
  assign step_amt    = amt_q;
  assign prop_off    = (state != ST_IDLE);
  assign done        = done_q;
  assign err         = err_q;

  pll_xover_meas #(.CW(CW)) u_meas (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (state == ST_STEP),
    .en      (state == ST_MEAS),
    .dir     (phase),
    .bb      (bb_lead),
    .timeout (timeout_cyc),
    .hit     (hit),
    .tout    (tout),
    .t_out   (t_meas)
  );

  pll_gain_ctrl #(.NSLICE(NSLICE), .INIT_CODE(INIT_CODE), .CW(CW)) u_gain (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .eval     (state == ST_EVAL),
    .t_adv    (t_adv),
    .t_ret    (t_ret),
    .target   (target_cyc),
    .stop     (stop),
    .slice_en (slice_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= 1'b0;
      scnt   <= '0;
      t_adv  <= '0;
      t_ret  <= '0;
      amt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_SETTLE;
          scnt  <= '0;
          phase <= 1'b0;
          err_q <= 1'b0;
          amt_q <= step_size;
        end
        ST_SETTLE: begin
          if (scnt_nxt >= {1'b0, settle_cyc}) state <= ST_STEP;
          else                                scnt  <= scnt_nxt[CW-1:0];
        end
        ST_STEP: state <= ST_MEAS;
        ST_MEAS: begin
          if (hit) begin
            if (!phase) begin
              t_adv <= t_meas;
              phase <= 1'b1;
              scnt  <= '0;
              state <= ST_SETTLE;
            end else begin
              t_ret <= t_meas;
              state <= ST_EVAL;
            end
          end else if (tout) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_EVAL: begin
          if (stop) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            phase <= 1'b0;
            scnt  <= '0;
            state <= ST_SETTLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  done_prop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !prop_off);
  // R3
  step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |=> !step_req);
  // R8
  tout_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tout |=> (err && done));
  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);
  // R5
  settle_before_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |-> ($past(state) == ST_SETTLE));
endmodule

// File: tb/pll_igain_cal_test.sv
module pll_igain_cal_test;
  localparam int CW = 16;
  localparam int SW = 8;
  localparam int NS = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          bb_lead = 1'b0;
  logic [CW-1:0] target_cyc = '0;
  logic [SW-1:0] step_size = '0;
  logic [CW-1:0] settle_cyc = 16'd4;
  logic [CW-1:0] timeout_cyc = 16'd300;
  logic          step_req, step_retard, prop_off, done, err;
  logic [SW-1:0] step_amt;
  logic [NS-1:0] slice_en;

  pll_igain_cal #(.CW(CW), .SW(SW), .NSLICE(NS), .INIT_CODE(5)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bb_lead(bb_lead),
    .target_cyc(target_cyc), .step_size(step_size), .settle_cyc(settle_cyc),
    .timeout_cyc(timeout_cyc), .step_req(step_req), .step_retard(step_retard),
    .step_amt(step_amt), .prop_off(prop_off), .slice_en(slice_en),
    .done(done), .err(err)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int base = 120, slope = 8, offs = 0;
  bit glitch_en = 0, tmo_mode = 0;
  int viol = 0, iv_bad = 0, done_n = 0;
  bit exp_dir = 0;
  int cur_settle = 4;
  int cur_size = 0;
  int cur_code = 5;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int delay_for(input bit retard, input int code);
    int f;
    if (tmo_mode) return 100000;
    f = base - slope * code;
    return retard ? f - offs : f + offs;
  endfunction

  // Expected final code per R6 and R7
  function automatic int model_final(input int code0, input int tgt);
    int code = code0;
    bit have = 0, lastup = 0;
    forever begin
      int ta, tr, avg;
      bit up, dn;
      ta = delay_for(1'b0, code);
      tr = delay_for(1'b1, code);
      avg = (ta + tr) / 2;
      up = avg > tgt;
      dn = avg < tgt;
      if (!up && !dn) return code;
      if (have && (up != lastup)) return code;
      if (up && code == NS) return code;
      if (dn && code == 1) return code;
      code = up ? code + 1 : code - 1;
      have = 1;
      lastup = up;
    end
  endfunction

  // Loop model driving the bang-bang detector
  initial begin
    int s = 0, dcur = 0, cyc = 0, adv_cyc = 0, adv_d = 0;
    bit oldp = 0, active = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (step_req) begin
        if (!prop_off) viol++;
        if (step_retard != exp_dir) viol++;
        if (int'(step_amt) != cur_size) viol++;
        exp_dir = ~exp_dir;
        s = 0;
        dcur = delay_for(step_retard, $countones(slice_en));
        oldp = ~step_retard;
        active = 1;
        bb_lead = oldp;
        if (!step_retard) begin
          adv_cyc = cyc;
          adv_d = dcur;
        end else if (cyc - adv_cyc != adv_d + 3 + cur_settle) begin
          iv_bad++;
          $display("FAIL R5 step spacing actual %0d expected %0d", cyc - adv_cyc, adv_d + 3 + cur_settle);
        end
      end else if (active) begin
        s++;
        bb_lead = (s <= dcur) ? oldp : ~oldp;
        if (glitch_en && dcur >= 4 && s == dcur - 2) bb_lead = ~oldp;
      end else begin
        bb_lead = 1'($urandom % 2);
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done) done_n++;
    end
  end

  task automatic run_cal(input int tgt, input int stl, input int sz, input bit mid, input string tag);
    int expc, code0;
    code0 = cur_code;
    expc = tmo_mode ? code0 : model_final(code0, tgt);
    @(negedge clk);
    target_cyc = CW'(tgt);
    settle_cyc = CW'(stl);
    step_size = SW'(sz);
    cur_settle = (stl < 1) ? 1 : stl;
    cur_size = sz;
    done_n = 0; viol = 0; iv_bad = 0; exp_dir = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(prop_off == 1'b1, {"R2 prop_off after start ", tag}, int'(prop_off), 1);
    if (mid) begin
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    do @(negedge clk); while (!done);
    chk(prop_off == 1'b0, {"R2 prop_off at done ", tag}, int'(prop_off), 0);
    chk($countones(slice_en) == expc, {"R6 R7 final code ", tag}, $countones(slice_en), expc);
    chk(slice_en == NS'((1 << expc) - 1), {"R1 thermometer form ", tag}, int'(slice_en), (1 << expc) - 1);
    chk(err == tmo_mode, {"R8 err flag ", tag}, int'(err), int'(tmo_mode));
    @(negedge clk);
    chk(done == 1'b0, {"R10 done pulse width ", tag}, int'(done), 0);
    repeat (3) @(negedge clk);
    chk(done_n == 1, {"R9 done count ", tag}, done_n, 1);
    chk(viol == 0, {"R2 R3 step request rules ", tag}, viol, 0);
    if (!tmo_mode) chk(iv_bad == 0, {"R4 R5 crossover spacing ", tag}, iv_bad, 0);
    cur_code = $countones(slice_en);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(slice_en == 10'h01F, "R1 reset slices", int'(slice_en), 'h1F);
    chk(prop_off == 1'b0 && step_req == 1'b0, "R1 reset prop_off/step_req", int'({prop_off, step_req}), 0);
    chk(done == 1'b0 && err == 1'b0, "R1 reset done/err", int'({done, err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 equality stop at start point
    base = 120; slope = 8; offs = 6;
    run_cal(120 - 8 * 5, 5, 3, 0, "equal");
    // R7 upper limit
    run_cal(1, 3, 2, 0, "top");
    // R7 lower limit
    run_cal(500, 7, 4, 0, "bottom");
    // R4 single-sample dither filtered
    glitch_en = 1; offs = 9;
    run_cal(70, 6, 5, 0, "dither");
    glitch_en = 0;
    // R9 start while busy
    run_cal(50, 10, 1, 1, "busy start");
    // R8 timeout, code unchanged; R10 err held
    tmo_mode = 1;
    timeout_cyc = 16'd60;
    run_cal(60, 4, 2, 0, "timeout");
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R10 err held after done", int'(err), 1);
    tmo_mode = 0;
    timeout_cyc = 16'd300;
    // R6 random patterns with offset cancellation
    for (int i = 0; i < 12; i++) begin
      base = 100 + int'($urandom % 41);
      slope = 3 + int'($urandom % 8);
      offs = int'($urandom % 11);
      glitch_en = 1'($urandom % 2);
      run_cal(10 + int'($urandom % 131), int'($urandom % 21), int'($urandom % 16), 0, "random");
    end
    chk(err == 1'b0, "R10 err cleared by new start", int'(err), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule